// File: doc/BRIEF.md
# Immediate-Load Execute Stage with Repeat Suppression

This block is the execute stage of a small 4-bit accumulator core. It holds the eight working nibble registers (A, E, L, H, X, W, Z, Y) and takes one decoded load-type instruction per cycle. The decoded instruction arrives as a class code, a destination register or pair index, an 8-bit immediate and an 8-bit direct address. The block updates the register file, or it issues a one-cycle data-memory write.

Immediate loads fall into suppressible groups. Loading A from an immediate and loading the EA pair from an immediate share one group. Loading the HL pair forms a second group. When immediate loads of the same group follow one another, only the first one takes effect. Each later one in the run becomes a no-operation. Any valid instruction outside that group ends the run. Every valid instruction is reported one cycle later with a flag that says whether it executed.

Top module: `imm_load_exec`

## Requirements
- R1: While reset is asserted and in the cycles after it, all eight registers read zero, `done_valid`, `done_exec` and `mem_we` are low, and the group history is empty, so the first immediate load executes.
- R2: Loads write the registers on the clock edge where the instruction is presented. Register indices are 0=A, 1=E, 2=L, 3=H, 4=X, 5=W, 6=Z, 7=Y, and `regs_o[4*i+3:4*i]` holds register i. Class 0 loads `imm[3:0]` into A. Class 1 loads `imm[3:0]` into register `dst`. Class 2 loads pair `dst[1:0]` (0=EA, 1=HL, 2=WX, 3=YZ), with `imm[7:4]` going to the first-named register and `imm[3:0]` to the second.
- R3: Class 3 copies register `dst` into A. Class 4 copies A into register `dst`. Class 7 changes no state.
- R4: Class 5 raises `mem_we` for exactly one cycle after its edge. `mem_addr` carries `addr`, and `mem_wdata` carries the value A held when the instruction was presented.
- R5: Class 6 behaves like class 5, except that `mem_addr` is `{H,L}` as those registers held when the instruction was presented.
- R6: Class 0, class 1 with `dst`=0, and class 2 with pair EA form the A group. A valid A-group load that directly follows a valid A-group instruction changes no register and is reported with `done_exec` low.
- R7: A class 2 load of pair HL forms its own group. A second consecutive HL load is suppressed in the same way.
- R8: Class 2 loads of WX or YZ always execute, even when repeated.
- R9: An immediate load whose group differs from the group of the previous valid instruction executes. For example, an A-group load directly after an HL load executes.
- R10: Any valid instruction outside the current group ends a run, and the next load of that group executes. Cycles with `in_valid` low leave the run state unchanged.
- R11: A suppressed load still counts as the previous instruction of its group, so a run of any length executes only its first member.
- R12: Each valid instruction produces `done_valid` high in the next cycle. `done_exec` is high in that cycle if and only if the instruction executed. Both are low after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present this cycle |
| in_class | input | 3 | Instruction class code |
| in_dst | input | 3 | Destination register index, or pair index in bits [1:0] |
| in_imm | input | 8 | Immediate operand |
| in_addr | input | 8 | Direct data-memory address |
| regs_o | output | 32 | Current register file, four bits per register |
| done_valid | output | 1 | Previous cycle carried a valid instruction |
| done_exec | output | 1 | That instruction executed (low means it was suppressed) |
| mem_we | output | 1 | Data-memory write strobe |
| mem_addr | output | 8 | Data-memory write address |
| mem_wdata | output | 4 | Data-memory write data |

## Verification
The assertions take two things for granted about the inputs. First, `in_valid` stays low while reset is applied and during the two synchronizer cycles after it, so `done_valid` never has to be traced back past reset. Second, the class, destination and operand fields are fully defined on every cycle where `in_valid` is high. The stimulus holds `in_valid` low through reset and for several cycles afterwards. It then drives only complete instructions on falling edges, and it places idle cycles deliberately to show that they hold the run state.

// File: rtl/imm_ld_pkg.sv
package imm_ld_pkg;
  localparam int NIB_W   = 4;
  localparam int NREGS   = 8;
  localparam int IDX_W   = $clog2(NREGS);
  localparam int ADDR_W  = 8;
  localparam int IMM_W   = 2 * NIB_W;
  localparam int RF_W    = NREGS * NIB_W;

  typedef enum logic [2:0] {
    CL_LDA_IMM  = 3'd0,
    CL_LDR_IMM  = 3'd1,
    CL_LDP_IMM  = 3'd2,
    CL_MOV_TO_A = 3'd3,
    CL_MOV_FR_A = 3'd4,
    CL_ST_DIR   = 3'd5,
    CL_ST_HL    = 3'd6,
    CL_NOP      = 3'd7
  } op_class_e;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_ACC  = 2'd1,
    GRP_HL   = 2'd2
  } sup_grp_e;

  localparam logic [IDX_W-1:0] IDX_A = 3'd0;
  localparam logic [IDX_W-1:0] IDX_L = 3'd2;
  localparam logic [IDX_W-1:0] IDX_H = 3'd3;
  localparam logic [1:0] PAIR_EA = 2'd0;
  localparam logic [1:0] PAIR_HL = 2'd1;
endpackage

// File: rtl/imm_ld_group_det.sv
module imm_ld_group_det
  import imm_ld_pkg::*;
(
  input  logic [2:0]       cls_i,
  input  logic [IDX_W-1:0] dst_i,
  output sup_grp_e         grp_o
);
  always_comb begin
    grp_o = GRP_NONE;
    unique case (op_class_e'(cls_i))
      CL_LDA_IMM: grp_o = GRP_ACC;
      CL_LDR_IMM: if (dst_i == IDX_A) grp_o = GRP_ACC;
      CL_LDP_IMM: begin
        if (dst_i[1:0] == PAIR_EA)      grp_o = GRP_ACC;
        else if (dst_i[1:0] == PAIR_HL) grp_o = GRP_HL;
      end
      default: grp_o = GRP_NONE;
    endcase
  end
endmodule

// File: rtl/imm_ld_suppress.sv
module imm_ld_suppress
  import imm_ld_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     valid_i,
  input  sup_grp_e grp_i,
  output logic     suppress_o
);
  sup_grp_e prev_q, prev_d;
  logic     prev_en;

  assign prev_en    = valid_i;
  assign suppress_o = valid_i && (grp_i != GRP_NONE) && (grp_i == prev_q);

  always_comb begin
    prev_d = prev_q;
    if (prev_en) prev_d = grp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= GRP_NONE;
    else        prev_q <= prev_d;
  end

  // R10: an instruction outside any group means nothing is suppressed next cycle
  a_r10_other_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && grp_i == GRP_NONE) |=> !suppress_o);
endmodule

// File: rtl/imm_ld_regfile.sv
module imm_ld_regfile
  import imm_ld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREGS-1:0] we_i,
  input  logic [RF_W-1:0]  wd_i,
  output logic [RF_W-1:0]  rd_o
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [NIB_W-1:0] q, d;
    always_comb begin
      d = q;
      if (we_i[i]) d = wd_i[i*NIB_W +: NIB_W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign rd_o[i*NIB_W +: NIB_W] = q;
  end

  // R2: at most one pair (two nibbles) written per instruction
  always_comb begin
    if (rst_n) a_r2_write_width: assert ($countones(we_i) <= 2);
  end
endmodule

// File: rtl/imm_load_exec.sv
module imm_load_exec
  import imm_ld_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          in_class,
  input  logic [IDX_W-1:0]    in_dst,
  input  logic [IMM_W-1:0]    in_imm,
  input  logic [ADDR_W-1:0]   in_addr,
  output logic [RF_W-1:0]     regs_o,
  output logic                done_valid,
  output logic                done_exec,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [NIB_W-1:0]    mem_wdata
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sup_grp_e grp;
  logic     suppress, exec;

  imm_ld_group_det u_grp (
    .cls_i (in_class),
    .dst_i (in_dst),
    .grp_o (grp)
  );

  imm_ld_suppress u_sup (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .valid_i    (in_valid),
    .grp_i      (grp),
    .suppress_o (suppress)
  );

  assign exec = in_valid && !suppress;

  // write decode
  logic [NREGS-1:0] we;
  logic [RF_W-1:0]  wd;
  logic [NIB_W-1:0] acc, src_nib, reg_h, reg_l;
  logic             is_store;

  assign acc     = regs_o[IDX_A*NIB_W +: NIB_W];
  assign reg_h   = regs_o[IDX_H*NIB_W +: NIB_W];
  assign reg_l   = regs_o[IDX_L*NIB_W +: NIB_W];
  assign src_nib = regs_o[in_dst*NIB_W +: NIB_W];

  always_comb begin
    we       = '0;
    wd       = '0;
    is_store = 1'b0;
    unique case (op_class_e'(in_class))
      CL_LDA_IMM: begin
        we[IDX_A] = 1'b1;
        wd        = {NREGS{in_imm[NIB_W-1:0]}};
      end
      CL_LDR_IMM: begin
        we[in_dst] = 1'b1;
        wd         = {NREGS{in_imm[NIB_W-1:0]}};
      end
      CL_LDP_IMM: begin
        // pair p: low nibble reg 2p, high nibble reg 2p+1
        we[{in_dst[1:0], 1'b0}] = 1'b1;
        we[{in_dst[1:0], 1'b1}] = 1'b1;
        wd = {(NREGS/2){in_imm}};
      end
      CL_MOV_TO_A: begin
        we[IDX_A] = 1'b1;
        wd        = {NREGS{src_nib}};
      end
      CL_MOV_FR_A: begin
        we[in_dst] = 1'b1;
        wd         = {NREGS{acc}};
      end
      CL_ST_DIR, CL_ST_HL: is_store = 1'b1;
      default: ;
    endcase
    if (!exec) we = '0;
  end

  imm_ld_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we_i  (we),
    .wd_i  (wd),
    .rd_o  (regs_o)
  );

  // report and memory port
  logic              dv_d, de_d, mwe_d, mem_en;
  logic [ADDR_W-1:0] maddr_d;
  logic [NIB_W-1:0]  mdata_d;

  assign mem_en = exec && is_store;

  always_comb begin
    dv_d    = in_valid;
    de_d    = exec;
    mwe_d   = mem_en;
    maddr_d = mem_addr;
    mdata_d = mem_wdata;
    if (mem_en) begin
      maddr_d = (op_class_e'(in_class) == CL_ST_DIR) ? in_addr : {reg_h, reg_l};
      mdata_d = acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      done_valid <= 1'b0;
      done_exec  <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      done_valid <= dv_d;
      done_exec  <= de_d;
      mem_we     <= mwe_d;
      mem_addr   <= maddr_d;
      mem_wdata  <= mdata_d;
    end
  end

  // R6: a suppressed load leaves the register file and memory port untouched
  a_r6_suppressed_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    (in_valid && suppress) |=> ($stable(regs_o) && !mem_we && !done_exec));
  // R12: a report only follows a valid instruction
  a_r12_done_follows: assert property (@(posedge clk) disable iff (!rst_n_int)
    done_valid |-> $past(in_valid));
  // R4: a write strobe only comes from an executed instruction
  a_r4_store_strobe: assert property (@(posedge clk) disable iff (!rst_n_int)
    mem_we |-> (done_valid && done_exec));
  // R8: WX and YZ immediate loads are never suppressed
  a_r8_pair_free: assert property (@(posedge clk) disable iff (!rst_n_int)
    (in_valid && in_class == CL_LDP_IMM && in_dst[1]) |=> done_exec);
endmodule

// File: tb/tb_imm_load_exec.sv
module tb_imm_load_exec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_class, in_dst;
  logic [7:0]  in_imm, in_addr;
  logic [31:0] regs_o;
  logic        done_valid, done_exec, mem_we;
  logic [7:0]  mem_addr;
  logic [3:0]  mem_wdata;

  imm_load_exec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_dst(in_dst), .in_imm(in_imm), .in_addr(in_addr), .regs_o(regs_o),
    .done_valid(done_valid), .done_exec(done_exec), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  int m_reg[8];
  int m_prev;   // 0 none, 1 A group, 2 HL group

  function automatic int grp_of(int cls, int dst);
    if (cls == 0) return 1;
    if (cls == 1 && dst == 0) return 1;
    if (cls == 2 && (dst % 4) == 0) return 1;
    if (cls == 2 && (dst % 4) == 1) return 2;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag, input int ev, input int ee,
                         input int ew, input int ea, input int ed);
    int rf = 0;
    for (int i = 0; i < 8; i++) rf |= (m_reg[i] & 15) << (4*i);
    chk(tag, "regs", regs_o, rf);
    chk(tag, "done_valid", done_valid, ev);
    chk(tag, "done_exec", done_exec, ee);
    chk(tag, "mem_we", mem_we, ew);
    if (ew != 0) begin
      chk(tag, "mem_addr", mem_addr, ea);
      chk(tag, "mem_wdata", mem_wdata, ed);
    end
  endtask

  // present one instruction (or idle when v=0), step the model, compare
  task automatic step(input string tag, input bit v, input int cls,
                      input int dst, input int imm, input int addr = 0);
    int ee = 0, ew = 0, ea = 0, ed = 0, g, p;
    bit sup;
    in_valid = v; in_class = 3'(cls); in_dst = 3'(dst);
    in_imm = 8'(imm); in_addr = 8'(addr);
    if (v) begin
      g = grp_of(cls, dst);
      sup = (g != 0) && (g == m_prev);
      m_prev = g;
      if (!sup) begin
        ee = 1;
        case (cls)
          0: m_reg[0] = imm & 15;
          1: m_reg[dst] = imm & 15;
          2: begin p = dst % 4; m_reg[2*p+1] = (imm >> 4) & 15; m_reg[2*p] = imm & 15; end
          3: m_reg[0] = m_reg[dst];
          4: m_reg[dst] = m_reg[0];
          5: begin ew = 1; ea = addr & 255; ed = m_reg[0]; end
          6: begin ew = 1; ea = m_reg[3]*16 + m_reg[2]; ed = m_reg[0]; end
          default: ;
        endcase
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag, v, ee, ew, ea, ed);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = 0;
    m_prev = 0;
    rst_n = 1'b0; in_valid = 0; in_class = 0; in_dst = 0; in_imm = 0; in_addr = 0;
    repeat (3) @(negedge clk);
    compare("R1", 0, 0, 0, 0, 0);            // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1", 0, 0, 0, 0, 0);            // R1 after release

    // R2 basic loads, R1 first load executes
    step("R1", 1, 0, 0, 8'h01);
    step("R2", 1, 1, 1, 8'h05);              // E
    step("R2", 1, 2, 2, 8'hC7);              // WX: W=C X=7
    step("R2", 1, 2, 3, 8'h9E);              // YZ: Y=9 Z=E
    // R6 A group: A then EA then A, doc-style
    step("R6", 1, 0, 0, 8'h01);
    step("R6", 1, 2, 0, 8'h02);              // suppressed
    step("R6", 1, 0, 0, 8'h03);              // suppressed
    step("R10", 1, 5, 0, 0, 8'h23);          // store direct ends run, R4
    step("R7", 1, 2, 1, 8'h10);
    step("R7", 1, 2, 1, 8'h20);              // suppressed
    step("R9", 1, 0, 0, 8'h03);              // differs from HL: executes
    step("R6", 1, 2, 0, 8'h35);              // suppressed
    step("R5", 1, 6, 0, 0);                  // store via HL = 10
    // R8 repeated WX/YZ
    step("R8", 1, 2, 2, 8'h41);
    step("R8", 1, 2, 2, 8'h52);
    step("R8", 1, 2, 3, 8'h63);
    // R6 via class 1 dst A
    step("R6", 1, 1, 0, 8'h0A);
    step("R6", 1, 1, 0, 8'h0B);              // suppressed
    // R10 idle holds run state
    step("R10", 0, 0, 0, 8'hFF);
    step("R10", 1, 0, 0, 8'h0C);             // still suppressed
    step("R3", 1, 4, 5, 0);                  // W := A, ends run
    step("R10", 1, 0, 0, 8'h0D);             // executes again
    step("R3", 1, 3, 7, 0);                  // A := Y
    step("R3", 1, 7, 0, 8'h0F);              // nop class
    // R11 long run
    step("R11", 1, 2, 1, 8'hA4);
    for (int k = 0; k < 6; k++) step("R11", 1, 2, 1, 8'h11 * k);
    step("R5", 1, 6, 0, 0);
    step("R4", 1, 5, 0, 0, 8'hE7);
    step("R12", 0, 5, 0, 0, 8'h11);          // idle after store: strobe drops
    // R2 all single registers
    for (int r = 0; r < 8; r++) step("R2", 1, 1, r, 3 + r);
    for (int r = 0; r < 8; r++) begin
      step("R3", 1, 3, r, 0);
      step("R3", 1, 4, (r + 3) % 8, 0);
    end
    // mixed pseudo-random stream
    for (int k = 0; k < 400; k++) begin
      int c = $urandom_range(0, 9);
      if (c > 7) c = (c == 8) ? 0 : 2;
      step("R11", $urandom_range(0, 7) != 0, c, $urandom_range(0, 7),
           $urandom_range(0, 255), $urandom_range(0, 255));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule